// File: doc/BRIEF.md
# Multi-register block move sequencer

This block carries out a block transfer between a register file and word-addressed memory. A caller gives it the highest register index to move, a start address, a direction and two mode bits: auto-increment and prefix. The sequencer then moves the registers from that highest index down to index zero. Each register uses one 32-bit word, and the words sit at rising addresses, four bytes apart. It presents one memory request per word and holds that request until memory accepts it.

The start address comes in already computed. The caller picks it from the base register or from a prefix value. After the last word, the sequencer may update the base register. It does so when auto-increment is set. The value depends on whether a prefix supplied the start address. A one-cycle done pulse then marks completion. The register file is external, with one combinational read port and one write port driven by this block.

Top module: `blkmove_seq`

## Requirements
- R1: Registers move in the order Rn, Rn-1, down to R0. The word for Rn-k uses address start + 4*k, and only one register is read or written per accepted beat.
- R2: With `store_i`=1, each beat writes the current register contents to memory. `mem_we_o` is high and the full 32-bit value is on `mem_wdata_o`.
- R3: With `store_i`=0, each accepted beat writes the returned memory word into the register being walked. The write goes out on `rf_we_o`/`rf_waddr_o`/`rf_wdata_o` in the same cycle as the beat.
- R4: With auto-increment and no prefix, after the last word the base register receives start + 4*(n+1), the address just past the block.
- R5: With auto-increment and prefix, the base register receives the start address. This holds even when a load has just filled that register.
- R6: On a store with auto-increment and prefix, if the base register is among those stored, memory receives the start address in its slot instead of the register's old contents.
- R7: Without auto-increment, no base writeback occurs. Every register not loaded by the transfer keeps its value, and `rf_we_o` stays low in the done cycle.
- R8: While `mem_rdy_i` is low, the request, its address and the walk position hold. A word advances only on a cycle with `mem_req_o` and `mem_rdy_i` both high.
- R9: `busy_o` rises the cycle after an accepted start. With memory always ready, `done_o` is high for exactly one cycle, n+2 cycles after the start. `busy_o` falls the cycle after `done_o`.
- R10: A start pulse while `busy_o` is high is ignored. The running transfer completes with its original parameters, and memory and registers show no trace of the ignored request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| store_i | input | 1 | 1: registers to memory, 0: memory to registers |
| autoinc_i | input | 1 | Update the base register after the transfer |
| prefix_i | input | 1 | Start address came from a prefix value |
| last_idx_i | input | 4 | Highest register index n |
| base_idx_i | input | 4 | Base register index |
| start_addr_i | input | 32 | Byte address of the first word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with `mem_rdy_i` |
| mem_rdy_i | input | 1 | Memory accepts the current request |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |

## Verification
The bench targets the base register in each of its roles. It sits inside a stored block with a prefix, where a design that stores old contents leaves the wrong word in memory. It sits inside a loaded block with a prefix, where a design that skips the final writeback leaves the loaded word instead of the start address. It also appears without auto-increment, where a stray writeback would corrupt it. Single-register moves and full sixteen-register moves test the countdown ends; an off-by-one walker would miss R0 or overrun the block. Stalled memory tests that a design advancing without ready skips words. A start pulse in mid-transfer shows whether a second request can corrupt the running one.

// File: rtl/blkmove_pkg.sv
`timescale 1ns/1ps
// Shared types for the block move sequencer.
package blkmove_pkg;
    // Sequencer phases: idle, moving words, base update plus done.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WB   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/blkmove_walker.sv
`timescale 1ns/1ps
// Register index / address walker.
// Loads the highest index and start address, then on each step counts the
// index down by one and the address up by one word. Assumes the caller stops
// stepping once the index has reached zero.
module blkmove_walker #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [WORD_W-1:0] start_addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [WORD_W-1:0] addr_o,
    output logic              at_zero_o
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);

    // Index and address counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o  <= '0;
            addr_o <= '0;
        end else if (load_i) begin
            idx_o  <= last_idx_i;
            addr_o <= start_addr_i;
        end else if (step_i) begin
            addr_o <= addr_o + STEP;
            if (!at_zero_o) idx_o <= idx_o - 1'b1;
        end
    end

    // Last-word detect.
    assign at_zero_o = (idx_o == '0);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_o == $past(addr_o) + STEP)); // R1
    AST_IDX_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !at_zero_o) |=> (idx_o == $past(idx_o) - 1'b1)); // R1
endmodule

// File: rtl/blkmove_rfport.sv
`timescale 1ns/1ps
// Register file and write-data steering.
// During a transfer it reads the walked register and supplies the store
// data, substituting the start address for the base register when a prefix
// and auto-increment store covers it. It writes loaded words back, and in the
// writeback phase updates the base register when auto-increment is set.
// Purely combinational; assumes the register file read is combinational.
module blkmove_rfport #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              xfer_i,
    input  logic              wb_i,
    input  logic              beat_i,
    input  logic              store_i,
    input  logic              autoinc_i,
    input  logic              prefix_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [IDX_W-1:0]  base_idx_i,
    input  logic [WORD_W-1:0] start_addr_i,
    input  logic [WORD_W-1:0] cur_addr_i,
    input  logic [WORD_W-1:0] rf_rdata_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [IDX_W-1:0]  rf_raddr_o,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [WORD_W-1:0] rf_wdata_o,
    output logic [WORD_W-1:0] mem_wdata_o
);
    logic subst_base;

    // Store data: start address replaces the base register's own value.
    always_comb begin
        subst_base  = autoinc_i && prefix_i && (idx_i == base_idx_i);
        rf_raddr_o  = idx_i;
        mem_wdata_o = subst_base ? start_addr_i : rf_rdata_i;
    end

    // Register write: loaded word in transfer, base update in writeback.
    always_comb begin
        rf_we_o    = 1'b0;
        rf_waddr_o = idx_i;
        rf_wdata_o = mem_rdata_i;
        if (xfer_i && beat_i && !store_i) begin
            rf_we_o = 1'b1;
        end else if (wb_i && autoinc_i) begin
            rf_we_o    = 1'b1;
            rf_waddr_o = base_idx_i;
            rf_wdata_o = prefix_i ? start_addr_i : cur_addr_i;
        end
    end
endmodule

// File: rtl/blkmove_seq.sv
`timescale 1ns/1ps
// Multi-register block move sequencer (top).
// Accepts a start only when idle, walks registers from the highest index
// down to zero at rising word addresses, one word per accepted memory beat,
// then spends one cycle on the base writeback and the done pulse.
// Assumes the start address is already chosen (prefix or base) by the caller.
module blkmove_seq #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              store_i,
    input  logic              autoinc_i,
    input  logic              prefix_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [IDX_W-1:0]  base_idx_i,
    input  logic [WORD_W-1:0] start_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic [IDX_W-1:0]  rf_raddr_o,
    input  logic [WORD_W-1:0] rf_rdata_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [WORD_W-1:0] rf_wdata_o
);
    import blkmove_pkg::*;

    seq_state_e        state_q;
    logic              store_q, autoinc_q, prefix_q;
    logic [IDX_W-1:0]  base_q;
    logic [WORD_W-1:0] start_q;
    logic              accept, beat, at_zero;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] addr;

    // Start is taken only in idle; a beat is an accepted request.
    assign accept = (state_q == ST_IDLE) && start_i;
    assign beat   = (state_q == ST_XFER) && mem_rdy_i;

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_XFER;
                ST_XFER: if (beat && at_zero) state_q <= ST_WB;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture of the transfer parameters at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q   <= 1'b0;
            autoinc_q <= 1'b0;
            prefix_q  <= 1'b0;
            base_q    <= '0;
            start_q   <= '0;
        end else if (accept) begin
            store_q   <= store_i;
            autoinc_q <= autoinc_i;
            prefix_q  <= prefix_i;
            base_q    <= base_idx_i;
            start_q   <= start_addr_i;
        end
    end

    blkmove_walker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .step_i       (beat),
        .last_idx_i   (last_idx_i),
        .start_addr_i (start_addr_i),
        .idx_o        (idx),
        .addr_o       (addr),
        .at_zero_o    (at_zero)
    );

    blkmove_rfport #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rfport (
        .xfer_i       (state_q == ST_XFER),
        .wb_i         (state_q == ST_WB),
        .beat_i       (beat),
        .store_i      (store_q),
        .autoinc_i    (autoinc_q),
        .prefix_i     (prefix_q),
        .idx_i        (idx),
        .base_idx_i   (base_q),
        .start_addr_i (start_q),
        .cur_addr_i   (addr),
        .rf_rdata_i   (rf_rdata_i),
        .mem_rdata_i  (mem_rdata_i),
        .rf_raddr_o   (rf_raddr_o),
        .rf_we_o      (rf_we_o),
        .rf_waddr_o   (rf_waddr_o),
        .rf_wdata_o   (rf_wdata_o),
        .mem_wdata_o  (mem_wdata_o)
    );

    // Memory request and status outputs.
    assign mem_req_o  = (state_q == ST_XFER);
    assign mem_we_o   = mem_req_o && store_q;
    assign mem_addr_o = addr;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_WB);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(rf_raddr_o))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !rf_we_o)); // R10
    AST_NO_WB_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !autoinc_q) |-> !rf_we_o); // R7
    AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && mem_req_o) |-> (!mem_we_o && mem_rdy_i)); // R3
endmodule

// File: tb/test_blkmove_seq.sv
`timescale 1ns/1ps
module test_blkmove_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, store_i = 1'b0, autoinc_i = 1'b0, prefix_i = 1'b0;
    logic [3:0]  last_idx_i = '0, base_idx_i = '0;
    logic [31:0] start_addr_i = '0;
    logic        busy_o, done_o, mem_req_o, mem_we_o, rf_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
    logic        mem_rdy_i = 1'b0;
    logic [3:0]  rf_raddr_o, rf_waddr_o;

    logic [31:0] regs [16];
    logic [31:0] mem  [512];
    int n_checks = 0, n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    assign rf_rdata_i  = regs[rf_raddr_o];
    assign mem_rdata_i = mem[mem_addr_o[10:2]];

    blkmove_seq i_blkmove_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i),
        .autoinc_i(autoinc_i), .prefix_i(prefix_i), .last_idx_i(last_idx_i),
        .base_idx_i(base_idx_i), .start_addr_i(start_addr_i),
        .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_rdy_i(mem_rdy_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
    );

    // Fields: [0] store, [1] autoinc, [2] prefix, [3] stall, [7:4] n, [11:8] base, [20:12] start word
    localparam int NVEC = 8;
    localparam logic [20:0] VEC [NVEC] = '{
        {9'd16,  4'd2,  4'd3,  4'b0011},
        {9'd40,  4'd9,  4'd5,  4'b0010},
        {9'd60,  4'd2,  4'd4,  4'b0111},
        {9'd80,  4'd7,  4'd2,  4'b0110},
        {9'd100, 4'd5,  4'd0,  4'b0001},
        {9'd120, 4'd3,  4'd15, 4'b0100},
        {9'd200, 4'd12, 4'd6,  4'b1011},
        {9'd300, 4'd1,  4'd3,  4'b1110}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input bit ai, input bit pf, input bit stall,
                          input int n, input int base, input int sw, input int tag, input bit intrude);
        logic [31:0] r0 [16];
        logic [31:0] m0 [512];
        logic [31:0] er [16];
        logic [31:0] em [512];
        logic [31:0] sa;
        int k, cyc;
        bit rdy;
        sa = 32'(sw * 4);
        for (int i = 0; i < 16; i++) regs[i] = 32'hA000_0000 + 32'(i * 32'h111) + 32'(tag << 20);
        for (int w = 0; w < 512; w++) mem[w] = 32'hB000_0000 + 32'(w) + 32'(tag << 16);
        for (int i = 0; i < 16; i++) r0[i] = regs[i];
        for (int w = 0; w < 512; w++) m0[w] = mem[w];
        // expected state from the requirements
        for (int i = 0; i < 16; i++) er[i] = r0[i];
        for (int w = 0; w < 512; w++) em[w] = m0[w];
        for (int j = 0; j <= n; j++) begin
            if (st) em[sw + j] = (ai && pf && base == n - j) ? sa : r0[n - j];
            else    er[n - j] = m0[sw + j];
        end
        if (ai) er[base] = pf ? sa : sa + 32'(4 * (n + 1));

        @(negedge clk);
        start_i = 1'b1; store_i = st; autoinc_i = ai; prefix_i = pf;
        last_idx_i = 4'(n); base_idx_i = 4'(base); start_addr_i = sa;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; cyc = 0;
        while (1) begin
            if (cyc != 0) @(negedge clk);
            cyc++;
            rdy = stall ? ((cyc % 3) == 2) : 1'b1;
            mem_rdy_i = rdy;
            start_i = 1'b0;
            if (intrude && k == 1) begin
                start_i = 1'b1; store_i = ~st; autoinc_i = 1'b1; prefix_i = 1'b0;
                last_idx_i = 4'd7; base_idx_i = 4'd0; start_addr_i = 32'd1600;
            end
            #1;
            if (cyc == 1) check(busy_o === 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
            if (mem_req_o && rdy) begin
                check(mem_addr_o === sa + 32'(4 * k), "R1 beat address", mem_addr_o, sa + 32'(4 * k));
                if (st) begin
                    check(mem_we_o === 1'b1, "R2 write beat", 32'(mem_we_o), 32'd1);
                    mem[mem_addr_o[10:2]] = mem_wdata_o;
                end else begin
                    check(rf_we_o === 1'b1 && rf_waddr_o === 4'(n - k), "R3 load target",
                          32'(rf_waddr_o), 32'(n - k));
                end
                k++;
            end
            if (rf_we_o) regs[rf_waddr_o] = rf_wdata_o;
            if (done_o) break;
            if (cyc > 200) break;
        end
        mem_rdy_i = 1'b0;
        start_i = 1'b0;
        check(k == n + 1, "R1 beat count", 32'(k), 32'(n + 1));
        if (!stall) check(cyc == n + 2, "R9 done timing", 32'(cyc), 32'(n + 2));
        if (!ai) check(rf_we_o === 1'b0, "R7 no writeback in done cycle", 32'(rf_we_o), 32'd0);
        @(negedge clk); #1;
        check(done_o === 1'b0 && busy_o === 1'b0, "R9 done one cycle", {30'd0, done_o, busy_o}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            if (i == base && ai && pf)       check(regs[i] === er[i], "R5 base gets start", regs[i], er[i]);
            else if (i == base && ai)        check(regs[i] === er[i], "R4 base past block", regs[i], er[i]);
            else if (i == base)              check(regs[i] === er[i], "R7 base untouched", regs[i], er[i]);
            else if (intrude)                check(regs[i] === er[i], "R10 register state", regs[i], er[i]);
            else                             check(regs[i] === er[i], "R3 register state", regs[i], er[i]);
        end
        for (int w = 0; w < 512; w++) begin
            if (mem[w] !== em[w]) begin
                if (st && ai && pf && (w - sw) == n - base) check(1'b0, "R6 base slot", mem[w], em[w]);
                else if (intrude)                          check(1'b0, "R10 memory state", mem[w], em[w]);
                else                                       check(1'b0, "R2 memory state", mem[w], em[w]);
            end
        end
        check(1'b1, "R2 memory compare", 32'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(busy_o === 1'b0 && done_o === 1'b0 && mem_req_o === 1'b0 && rf_we_o === 1'b0,
              "R9 reset state", {28'd0, busy_o, done_o, mem_req_o, rf_we_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                   int'(VEC[v][7:4]), int'(VEC[v][11:8]), int'(VEC[v][20:12]), v, 1'b0);
        end
        // R10: start pulses mid-transfer must be ignored
        run_op(1'b1, 1'b1, 1'b0, 1'b0, 2, 4, 20, 9, 1'b1);
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 3, 2, 30, 10, 1'b1);
        // R6 with base at highest and lowest register
        run_op(1'b1, 1'b1, 1'b1, 1'b0, 5, 5, 140, 11, 1'b0);
        run_op(1'b1, 1'b1, 1'b1, 1'b1, 5, 0, 160, 12, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule